// File: doc/BRIEF.md
# Jitter-Sampled Hybrid Random Bit Source

This block generates random bits for slot choice during tag anticollision and for security nonces. A slow clock with large period jitter samples the level of the fast system clock in a flip-flop, which gives a raw physical bit. The same slow clock steps a 5-bit pseudo-random generator. The output bit is drawn either from the physical sample or from the pseudo-random state, and a second pseudo-random state bit decides which.

A requester in the fast domain raises `en` and waits for `rdy`. While `rdy` is high it reads `rbit`. Every further enabled slow edge produces a fresh bit, and `rdy` stays high throughout. Dropping `en` ends the request and freezes the generator. The oscillators are outside the block, so both clocks arrive as ports.

Top module: `hybrid_rbit_src`

## Requirements
- R1: After reset, `rdy` and `rbit` are 0 and the pseudo-random state is 00000.
- R2: On each slow-clock rising edge where `en` is high, the block captures the fast-clock level as the physical bit.
- R3: On each such edge the 5-bit state s steps to {s[3:0], s[4]^s[2]^(s[3:0]==0)}. Starting from 00000, this visits all 32 states and then repeats.
- R4: The bit issued after an enabled edge is the new s[4] ? physical bit : new s[0].
- R5: After `en` rises, `rdy` stays 0 until the first slow rising edge. It goes to 1 within three fast-clock cycles of that edge.
- R6: While `en` stays high, `rdy` stays 1. After each later enabled slow edge, `rbit` shows the new bit within three fast-clock cycles.
- R7: While `en` is 0, `rdy` is 0. Slow edges that occur while `en` is 0 neither step the state nor produce a bit, so the sequence resumes where it stopped.
- R8: `rbit` is 0 whenever `rdy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fclk | input | 1 | Fast system clock; also the data sampled by the slow clock |
| sclk | input | 1 | Slow, jittery sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Request, in the fast domain |
| rdy | output | 1 | Bit valid, in the fast domain |
| rbit | output | 1 | Random bit, valid while `rdy` is 1 |

## Verification
The hardest situation to reach from the ports is knowing the physical bit in advance, because it depends on where each jittered slow edge falls in the fast period. The bench places every slow edge at a randomly chosen offset of either a quarter or three quarters into a fast period, so the captured level is known arithmetically. The gap between edges is also randomised. Running more than two full 32-step periods, with idle slow edges inserted while the request is low, exposes every state, both mux selections and the resumption after a hold.

// File: rtl/rbit_pkg.sv
package rbit_pkg;
  localparam int PRN_W = 5;

  // Maximal 5-bit recurrence extended with the all-zero state (32 states)
  function automatic logic [PRN_W-1:0] prn_next(input logic [PRN_W-1:0] s);
    logic fb;
    fb = s[4] ^ s[2] ^ (s[3:0] == 4'b0000);
    return {s[3:0], fb};
  endfunction
endpackage

// File: rtl/rbit_rst_sync.sv
module rbit_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/rbit_prng.sv
module rbit_prng
  import rbit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic             sel,
  output logic             dat
);
  logic [PRN_W-1:0] state_q;
  logic [PRN_W-1:0] state_d;

  always_comb begin
    state_d = state_q;
    if (step) state_d = prn_next(state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign sel = state_q[PRN_W-1];
  assign dat = state_q[0];

  a_r7_prng_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state_q));
  a_r3_leave_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (step && state_q == 5'b00000) |=> state_q == 5'b00001);
  a_r3_enter_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (step && state_q == 5'b10000) |=> state_q == 5'b00000);
endmodule

// File: rtl/rbit_slow.sv
module rbit_slow (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic fast_lvl,
  output logic bit_o,
  output logic tog_o
);
  logic phys_q, phys_d;
  logic tog_q, tog_d;
  logic sel, dat;

  rbit_prng u_prng (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (en),
    .sel   (sel),
    .dat   (dat)
  );

  always_comb begin
    phys_d = phys_q;
    tog_d  = tog_q;
    if (en) begin
      phys_d = fast_lvl;
      tog_d  = ~tog_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phys_q <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      phys_q <= phys_d;
      tog_q  <= tog_d;
    end
  end

  assign bit_o = sel ? phys_q : dat;
  assign tog_o = tog_q;

  a_r2_token_flips: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> tog_q != $past(tog_q));
  a_r7_sample_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(phys_q) && $stable(tog_q)));
endmodule

// File: rtl/rbit_xfer.sv
module rbit_xfer #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tog_s,
  input  logic bit_s,
  output logic rdy,
  output logic rbit
);
  logic [SYNC-1:0] sync_q;
  logic            seen_q, got_q, got_d, bit_q, bit_d, chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= 1'b0;
    else        sync_q[0] <= tog_s;
  end

  for (genvar i = 1; i < SYNC; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[i] <= 1'b0;
      else        sync_q[i] <= sync_q[i-1];
    end
  end

  assign chg = sync_q[SYNC-1] ^ seen_q;

  always_comb begin
    got_d = en & (got_q | chg);
    bit_d = chg ? bit_s : bit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      got_q  <= 1'b0;
      bit_q  <= 1'b0;
    end else begin
      seen_q <= sync_q[SYNC-1];
      got_q  <= got_d;
      bit_q  <= bit_d;
    end
  end

  assign rdy  = en & got_q;
  assign rbit = rdy & bit_q;

  a_r5_rise_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(got_q) |-> $past(chg));
  a_r6_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (got_q && en) |=> got_q);
  a_r7_ready_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !got_q);
endmodule

// File: rtl/hybrid_rbit_src.sv
module hybrid_rbit_src #(
  parameter int SYNC = 2,
  parameter int RST_STAGES = 2
) (
  input  logic fclk,
  input  logic sclk,
  input  logic rst_n,
  input  logic en,
  output logic rdy,
  output logic rbit
);
  logic frst_n, srst_n, bit_s, tog_s;

  rbit_rst_sync #(.STAGES(RST_STAGES)) u_frst (
    .clk(fclk), .arst_n(rst_n), .srst_n(frst_n));
  rbit_rst_sync #(.STAGES(RST_STAGES)) u_srst (
    .clk(sclk), .arst_n(rst_n), .srst_n(srst_n));

  rbit_slow u_slow (
    .clk      (sclk),
    .rst_n    (srst_n),
    .en       (en),
    .fast_lvl (fclk),
    .bit_o    (bit_s),
    .tog_o    (tog_s)
  );

  rbit_xfer #(.SYNC(SYNC)) u_xfer (
    .clk   (fclk),
    .rst_n (frst_n),
    .en    (en),
    .tog_s (tog_s),
    .bit_s (bit_s),
    .rdy   (rdy),
    .rbit  (rbit)
  );

  a_r8_bit_gated: assert property (@(posedge fclk) disable iff (!frst_n)
    !en |=> !rbit);
endmodule

// File: tb/hybrid_rbit_src_test.sv
`timescale 1ns/1ps
module hybrid_rbit_src_test;
  logic fclk = 1'b1;
  logic sclk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic rdy, rbit;
  int   n_cmp = 0;
  int   n_bad = 0;
  logic [4:0] st = 5'b00000;

  hybrid_rbit_src uut (.fclk(fclk), .sclk(sclk), .rst_n(rst_n), .en(en),
                       .rdy(rdy), .rbit(rbit));

  always #10 fclk = ~fclk;

  task automatic chk(input logic act, input logic expv, input string req);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, expv, $time);
    end
  endtask

  // Slow edge placed a quarter (level 1) or three quarters (level 0) into a fast period
  task automatic slow_pulse(input logic hi);
    @(posedge fclk);
    #(hi ? 5 : 15) sclk = 1'b1;
    #100 sclk = 1'b0;
    repeat (2 + $urandom_range(20, 0)) @(posedge fclk);
    #3;
  endtask

  function automatic logic [4:0] step_of(input logic [4:0] s);
    logic fb;
    fb = s[4] ^ s[2] ^ (s[3:0] == 4'd0);
    return {s[3:0], fb};
  endfunction

  task automatic set_en(input logic v);
    @(posedge fclk);
    #2 en = v;
  endtask

  initial begin
    #3_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic hi, expv;
    repeat (3) @(posedge fclk);
    #2 rst_n = 1'b1;
    for (int i = 0; i < 3; i++) slow_pulse(1'b1);  // idle edges release slow reset
    chk(rdy, 1'b0, "R1 rdy");
    chk(rbit, 1'b0, "R1 rbit");

    // R5: no ready before the first slow edge
    set_en(1'b1);
    repeat (6) @(posedge fclk);
    #3 chk(rdy, 1'b0, "R5 before edge");
    chk(rbit, 1'b0, "R8 gated");

    // Long enabled run: more than two periods (R1, R2, R3, R4, R6)
    for (int k = 0; k < 70; k++) begin
      hi = 1'($urandom_range(1, 0));
      slow_pulse(hi);
      st   = step_of(st);
      expv = st[4] ? hi : st[0];
      chk(rdy, 1'b1, k == 0 ? "R5 after edge" : "R6 ready held");
      chk(rbit, expv, st[4] ? "R2 R4 physical" : "R3 R4 pseudo");
    end

    // R7: drop request, slow edges do not advance
    set_en(1'b0);
    #1 chk(rdy, 1'b0, "R7 drop");
    chk(rbit, 1'b0, "R8 gated low");
    for (int k = 0; k < 5; k++) begin
      slow_pulse(1'($urandom_range(1, 0)));
      chk(rdy, 1'b0, "R7 idle edge");
      chk(rbit, 1'b0, "R8 idle");
    end

    set_en(1'b1);
    repeat (5) @(posedge fclk);
    #3 chk(rdy, 1'b0, "R5 re-request");
    for (int k = 0; k < 36; k++) begin
      hi = 1'($urandom_range(1, 0));
      slow_pulse(hi);
      st   = step_of(st);
      expv = st[4] ? hi : st[0];
      chk(rdy, 1'b1, "R6 ready");
      chk(rbit, expv, "R7 resume R4");
    end
    set_en(1'b0);
    #1 chk(rdy, 1'b0, "R7 final drop");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule